// File: doc/BRIEF.md
# I2C Master Write Engine with Hardware NACK Abort

This block is an I2C master that only transmits. The host loads payload bytes into a 16-entry transmit FIFO, programs a 7-bit target address, a byte count and an SCL divider, and then issues a start command. The engine sends a START condition and the address byte with the write bit clear. It then pulls bytes from the FIFO one at a time and shifts each one out most significant bit first. It samples the acknowledge on the ninth SCL clock of every byte.

If the target refuses any byte, including the address, the engine ends the transfer by itself. It drives a STOP, returns to idle, sets a sticky refusal flag and raises `irq`. It does not touch the FIFO. Bytes that were never sent stay queued, so the FIFO-valid flag stays high, and the count register shows how much of the payload was left behind. The host must flush the FIFO with a control bit before it reuses the engine. A completion flag is set only when every byte has been acknowledged. Software that polls can therefore test the completion and refusal flags together and never wait forever.

The host port accepts a register access in any cycle and returns read data combinationally. Both bus lines are open-drain: an `_oe` output of 1 pulls the line low.

Top module: `i2cw_engine`

## Requirements
- R1: After a start command, the first byte the target receives is the target address in bits 7..1 with bit 0 = 0 (write), sent MSB first after a START. Every byte is followed by a ninth SCL clock on which SDA is sampled.
- R2: Each acknowledged byte lets the engine take the next FIFO entry. SIZE (register 2) drops by one when an entry is taken. STAT bit 0 (complete) is set when the ninth-clock sample of the byte that brought SIZE to zero is low. It is never set by a refused transfer.
- R3: A high SDA sample on the ninth clock of any byte ends the transfer without host action. A STOP is driven, the engine returns to idle, STAT bit 1 (refused) is set and `irq` goes high.
- R4: After a refusal on the address byte, SIZE keeps the value it had at start. After a refusal on a data byte, SIZE equals the number of payload bytes that follow the refused byte.
- R5: STAT bit 3 reads 1 exactly when the FIFO holds at least one entry. After a refusal it stays 1 while unsent entries remain and reads 0 when the refused byte was the last entry.
- R6: Writing CTRL (register 0) with bit 1 set empties the FIFO one cycle later. The fill level (read of register 3) then reads 0 and STAT bit 3 reads 0.
- R7: The FIFO holds 16 entries. A write to TXDATA (register 3) while it is full is dropped and sets the sticky STAT bit 2 (overflow). The 16 accepted entries are sent unchanged.
- R8: A start command (CTRL bit 0) is ignored while STAT bit 1 is set. Writing 1 to a STAT bit among bits 0..2 clears it, and clearing bit 1 drops `irq`.
- R9: Every SCL high phase inside a byte lasts 2*(DIV+1) clock cycles, where DIV is register 5. SDA changes while SCL is high only to form START or STOP.
- R10: After reset both line drivers are released, `irq` is low, STAT reads 0 and DIV reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Access accepted (always 1) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register select: 0 CTRL, 1 TARGET, 2 SIZE, 3 TXDATA/level, 4 STAT, 5 DIV |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Transfer-refused interrupt, follows STAT bit 1 |

## Verification
A corrupted count or FIFO pointer shows up at the register port as soon as the transfer ends: SIZE and the FIFO-valid bit no longer match the byte index at which the bench model refused. A bit sequencer that is off by one shows up within a single byte, either as a wrong first byte at the bench target or as an acknowledge sampled on the wrong clock, which turns a refusal into a completion. A sequencing fault in the divider or the line drivers changes the measured SCL high time, or moves SDA while SCL is high, within the first bit.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int TADDR_W = 7;
  localparam int RA_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SHIFT,
    ST_ACK,
    ST_LOAD,
    ST_STOP
  } xfer_st_t;

  localparam logic [RA_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [RA_W-1:0] RA_TARGET = 3'd1;
  localparam logic [RA_W-1:0] RA_SIZE   = 3'd2;
  localparam logic [RA_W-1:0] RA_TXDATA = 3'd3;
  localparam logic [RA_W-1:0] RA_STAT   = 3'd4;
  localparam logic [RA_W-1:0] RA_DIV    = 3'd5;

  localparam int CB_GO    = 0;
  localparam int CB_FLUSH = 1;

  localparam int SB_DONE = 0;
  localparam int SB_NACK = 1;
  localparam int SB_OVF  = 2;
  localparam int SB_TXV  = 3;
  localparam int SB_BUSY = 4;
endpackage

// File: rtl/i2cw_fifo.sv
module i2cw_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [WIDTH-1:0]       wdata,
  input  logic                   pop,
  input  logic                   flush,
  output logic [WIDTH-1:0]       rdata,
  output logic                   full,
  output logic                   empty,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0] wr_ptr_q, wr_ptr_d;
  logic [AW:0] rd_ptr_q, rd_ptr_d;
  logic push_ok, pop_ok;

  always_comb begin
    level   = wr_ptr_q - rd_ptr_q;
    full    = (level == (AW+1)'(DEPTH));
    empty   = (level == '0);
    push_ok = push && !full && !flush;
    pop_ok  = pop && !empty && !flush;
    rdata   = mem_q[rd_ptr_q[AW-1:0]];
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/i2cw_qtick.sv
module i2cw_qtick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cw_xfer_fsm.sv
module i2cw_xfer_fsm
  import i2cw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [TADDR_W-1:0] target,
  input  logic               cnt_zero,
  input  logic               fifo_empty,
  input  logic [BYTE_W-1:0]  fifo_data,
  input  logic               sda_in,
  output logic               pop,
  output logic               nack_evt,
  output logic               done_evt,
  output logic               scl_oe,
  output logic               sda_oe,
  output xfer_st_t           state
);
  localparam int BIT_W = $clog2(BYTE_W);

  xfer_st_t st_q, st_d;
  logic [1:0] q_q, q_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic last_q;

  assign last_q = (q_q == 2'd3);
  assign state  = st_q;

  always_comb begin
    st_d = st_q;
    q_d = q_q;
    bit_d = bit_q;
    sh_d = sh_q;
    pop = 1'b0;
    nack_evt = 1'b0;
    done_evt = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_START;
          q_d   = 2'd0;
          sh_d  = {target, 1'b0};
          bit_d = BIT_W'(BYTE_W-1);
        end
      end
      ST_START: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (last_q) st_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (last_q) begin
            if (bit_q == '0) begin
              st_d = ST_ACK;
            end else begin
              bit_d = bit_q - 1'b1;
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
      end
      ST_ACK: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (last_q) begin
            if (sda_in) begin
              nack_evt = 1'b1;
              st_d = ST_STOP;
            end else if (cnt_zero) begin
              done_evt = 1'b1;
              st_d = ST_STOP;
            end else begin
              st_d = ST_LOAD;
            end
          end
        end
      end
      ST_LOAD: begin
        if (!fifo_empty) begin
          pop   = 1'b1;
          sh_d  = fifo_data;
          bit_d = BIT_W'(BYTE_W-1);
          q_d   = 2'd0;
          st_d  = ST_SHIFT;
        end
      end
      ST_STOP: begin
        if (tick) begin
          q_d = q_q + 2'd1;
          if (last_q) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      ST_START: begin scl_oe = last_q;     sda_oe = q_q[1];    end
      ST_SHIFT: begin scl_oe = ~q_q[1];    sda_oe = ~sh_q[BYTE_W-1]; end
      ST_ACK:   begin scl_oe = ~q_q[1];    sda_oe = 1'b0;      end
      ST_LOAD:  begin scl_oe = 1'b1;       sda_oe = 1'b0;      end
      ST_STOP:  begin scl_oe = (q_q == 2'd0); sda_oe = ~q_q[1]; end
      default:  begin scl_oe = 1'b0;       sda_oe = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      q_q   <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      q_q   <= q_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int                FIFO_DEPTH = 16,
  parameter logic [BYTE_W-1:0] DIV_RST    = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [RA_W-1:0]   host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
  localparam int CNT_W = BYTE_W;
  localparam int DIV_W = BYTE_W;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [1:0] sda_pipe_q;

  logic [TADDR_W-1:0] target_q, target_d;
  logic [CNT_W-1:0]   size_q, size_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic st_done_q, st_done_d;
  logic st_nack_q, st_nack_d;
  logic st_ovf_q, st_ovf_d;
  logic flush_q, flush_d;

  logic wr_en, wr_ctrl, wr_target, wr_size, wr_data, wr_stat, wr_div;
  logic go_ok, busy;
  logic tick;
  logic fifo_pop, fifo_full, fifo_empty;
  logic [BYTE_W-1:0] fifo_q;
  logic [LVL_W-1:0]  fifo_level;
  logic nack_evt, done_evt;
  xfer_st_t fsm_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sda_pipe_q <= '1;
    else            sda_pipe_q <= {sda_pipe_q[0], sda_i};
  end

  assign host_ready = 1'b1;
  assign busy = (fsm_state != ST_IDLE);
  assign irq = st_nack_q;

  always_comb begin
    wr_en     = host_valid && host_we;
    wr_ctrl   = wr_en && (host_addr == RA_CTRL);
    wr_target = wr_en && (host_addr == RA_TARGET);
    wr_size   = wr_en && (host_addr == RA_SIZE);
    wr_data   = wr_en && (host_addr == RA_TXDATA);
    wr_stat   = wr_en && (host_addr == RA_STAT);
    wr_div    = wr_en && (host_addr == RA_DIV);
    go_ok     = wr_ctrl && host_wdata[CB_GO] && !busy && !st_nack_q;
  end

  always_comb begin
    target_d = wr_target ? host_wdata[TADDR_W-1:0] : target_q;
    div_d    = wr_div ? host_wdata : div_q;
    flush_d  = wr_ctrl && host_wdata[CB_FLUSH];

    size_d = size_q;
    if (wr_size && !busy) size_d = host_wdata;
    else if (fifo_pop)    size_d = size_q - 1'b1;

    st_done_d = st_done_q;
    if (wr_stat && host_wdata[SB_DONE]) st_done_d = 1'b0;
    if (done_evt)                       st_done_d = 1'b1;

    st_nack_d = st_nack_q;
    if (wr_stat && host_wdata[SB_NACK]) st_nack_d = 1'b0;
    if (nack_evt)                       st_nack_d = 1'b1;

    st_ovf_d = st_ovf_q;
    if (wr_stat && host_wdata[SB_OVF]) st_ovf_d = 1'b0;
    if (wr_data && fifo_full)          st_ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      target_q  <= '0;
      size_q    <= '0;
      div_q     <= DIV_RST;
      st_done_q <= 1'b0;
      st_nack_q <= 1'b0;
      st_ovf_q  <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      target_q  <= target_d;
      size_q    <= size_d;
      div_q     <= div_d;
      st_done_q <= st_done_d;
      st_nack_q <= st_nack_d;
      st_ovf_q  <= st_ovf_d;
      flush_q   <= flush_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      RA_TARGET: host_rdata = BYTE_W'(target_q);
      RA_SIZE:   host_rdata = size_q;
      RA_TXDATA: host_rdata = BYTE_W'(fifo_level);
      RA_STAT: begin
        host_rdata[SB_DONE] = st_done_q;
        host_rdata[SB_NACK] = st_nack_q;
        host_rdata[SB_OVF]  = st_ovf_q;
        host_rdata[SB_TXV]  = !fifo_empty;
        host_rdata[SB_BUSY] = busy;
      end
      RA_DIV:    host_rdata = div_q;
      default:   host_rdata = '0;
    endcase
  end

  i2cw_fifo #(
    .DEPTH(FIFO_DEPTH),
    .WIDTH(BYTE_W)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (wr_data),
    .wdata (host_wdata),
    .pop   (fifo_pop),
    .flush (flush_q),
    .rdata (fifo_q),
    .full  (fifo_full),
    .empty (fifo_empty),
    .level (fifo_level)
  );

  i2cw_qtick #(
    .DIV_W(DIV_W)
  ) u_qtick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (busy),
    .div   (div_q),
    .tick  (tick)
  );

  i2cw_xfer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .start      (go_ok),
    .target     (target_q),
    .cnt_zero   (size_q == '0),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_q),
    .sda_in     (sda_pipe_q[1]),
    .pop        (fifo_pop),
    .nack_evt   (nack_evt),
    .done_evt   (done_evt),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .state      (fsm_state)
  );
endmodule

// File: rtl/i2cw_engine_chk.sv
module i2cw_engine_chk
  import i2cw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input xfer_st_t          state,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              st_nack,
  input logic              st_done,
  input logic              pop,
  input logic [BYTE_W-1:0] size,
  input logic [LVL_W-1:0]  level,
  input logic              flush
);
  // R9: SDA may move under a high SCL only while forming START or STOP
  a_r9_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ($past(state) == ST_START || $past(state) == ST_STOP));

  // R3: the refusal flag rises only out of an acknowledge slot
  a_r3_nack_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_nack) |-> ($past(state) == ST_ACK));

  // R3: a refusal sends the engine straight to STOP
  a_r3_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_nack) |-> (state == ST_STOP));

  // R2: every FIFO take lowers the size register by one
  a_r2_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ((size + 1'b1) == $past(size)));

  // R2: completion never appears together with a refusal
  a_r2_done_not_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> !st_nack);

  // R7: fill level never passes the depth
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R6: a flush pulse leaves the FIFO empty
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  // R8: an idle engine with the refusal flag set stays idle
  a_r8_blocked_by_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && st_nack) |=> (state == ST_IDLE));
endmodule

bind i2cw_engine i2cw_engine_chk #(
  .DEPTH(FIFO_DEPTH),
  .LVL_W(LVL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .state   (fsm_state),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .st_nack (st_nack_q),
  .st_done (st_done_q),
  .pop     (fifo_pop),
  .size    (size_q),
  .level   (fifo_level),
  .flush   (flush_q)
);

// File: tb/test_i2cw_engine.sv
`timescale 1ns/1ps
module test_i2cw_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       host_valid = 1'b0;
  logic       host_ready;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic scl_oe, sda_oe, irq;
  logic slv_low = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_low);

  i2cw_engine i_i2cw_engine (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int nack_at = 99;

  // target model, sampled between clock edges
  int bitcnt = 0, xfer_bytes = 0, start_cnt = 0, stop_cnt = 0;
  logic [7:0] shreg = 8'd0, first_byte = 8'd0, last_byte = 8'd0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitcnt = 0; slv_low = 1'b0; prev_scl = 1'b1; prev_sda = 1'b1;
    end else begin
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        start_cnt++; bitcnt = 0; xfer_bytes = 0;
      end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
        stop_cnt++; bitcnt = 0; slv_low = 1'b0;
      end else if (!prev_scl && scl_line) begin
        if (bitcnt < 8) begin
          shreg = {shreg[6:0], sda_line};
          bitcnt++;
          if (bitcnt == 8) begin
            if (xfer_bytes == 0) first_byte = shreg;
            last_byte = shreg;
            xfer_bytes++;
          end
        end else if (bitcnt == 8) begin
          bitcnt = 9;
        end
      end else if (prev_scl && !scl_line) begin
        if (bitcnt == 8 && (xfer_bytes - 1) != nack_at) slv_low = 1'b1;
        if (bitcnt == 9) begin slv_low = 1'b0; bitcnt = 0; end
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd4, s);
      if (!s[4]) break;
    end
  endtask

  // load, size, refuse-at (0 = address), residual, done, nack, txvalid, bytes seen
  localparam int NV = 7;
  localparam int VEC [NV][8] = '{
    '{3, 3, 99, 0, 1, 0, 0, 4},
    '{4, 4,  0, 4, 0, 1, 1, 1},
    '{4, 4,  2, 2, 0, 1, 1, 3},
    '{3, 3,  3, 0, 0, 1, 0, 4},
    '{5, 2, 99, 0, 1, 0, 1, 3},
    '{0, 0, 99, 0, 1, 0, 0, 1},
    '{2, 2,  1, 1, 0, 1, 1, 2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, z;
    int s0, p0, hi;
    repeat (4) @(negedge clk);
    chk("R10 scl released in reset", int'(scl_oe), 0);
    chk("R10 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, s);  chk("R10 status after reset", int'(s), 0);
    rd(3'd5, s);  chk("R10 divider after reset", int'(s), 4);
    chk("R10 irq after reset", int'(irq), 0);
    chk("R10 host_ready", int'(host_ready), 1);

    wr(3'd5, 8'd1);
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, 8'h02);
      wr(3'd4, 8'h07);
      nack_at = VEC[v][2];
      wr(3'd1, 8'(8'h20 + v));
      for (int i = 0; i < VEC[v][0]; i++) wr(3'd3, 8'(16 * v + i));
      wr(3'd2, 8'(VEC[v][1]));
      p0 = stop_cnt;
      wr(3'd0, 8'h01);
      wait_idle();
      rd(3'd4, s);
      rd(3'd2, z);
      chk($sformatf("R2 complete v%0d", v), int'(s[0]), VEC[v][4]);
      chk($sformatf("R3 refused v%0d", v), int'(s[1]), VEC[v][5]);
      chk($sformatf("R3 irq v%0d", v), int'(irq), VEC[v][5]);
      chk($sformatf("R3 stop driven v%0d", v), stop_cnt - p0, 1);
      chk($sformatf("R4 residual v%0d", v), int'(z), VEC[v][3]);
      chk($sformatf("R5 txvalid v%0d", v), int'(s[3]), VEC[v][6]);
      chk($sformatf("R1 bytes seen v%0d", v), xfer_bytes, VEC[v][7]);
      chk($sformatf("R1 address byte v%0d", v), int'(first_byte), (32 + v) * 2);
    end

    // R8: refusal flag still set from the last vector
    s0 = start_cnt;
    wr(3'd0, 8'h01);
    repeat (40) @(negedge clk);
    rd(3'd4, s);
    chk("R8 start ignored, no START", start_cnt - s0, 0);
    chk("R8 start ignored, not busy", int'(s[4]), 0);
    wr(3'd4, 8'h02);
    rd(3'd4, s);
    chk("R8 W1C clears refusal", int'(s[1]), 0);
    chk("R8 W1C drops irq", int'(irq), 0);

    // R7: seventeenth write is dropped
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h07);
    nack_at = 99;
    for (int i = 0; i < 17; i++) wr(3'd3, 8'(8'hC0 + i));
    rd(3'd4, s);  chk("R7 overflow flag", int'(s[2]), 1);
    rd(3'd3, z);  chk("R7 level at full", int'(z), 16);
    wr(3'd1, 8'h33);
    wr(3'd2, 8'd16);
    wr(3'd0, 8'h01);
    wait_idle();
    rd(3'd4, s);
    chk("R7 full burst complete", int'(s[0]), 1);
    chk("R7 bytes seen", xfer_bytes, 17);
    chk("R7 last byte kept", int'(last_byte), 8'hCF);

    // R6: flush
    wr(3'd4, 8'h07);
    for (int i = 0; i < 3; i++) wr(3'd3, 8'(i));
    rd(3'd3, z);  chk("R6 level before flush", int'(z), 3);
    wr(3'd0, 8'h02);
    rd(3'd3, z);  chk("R6 level after flush", int'(z), 0);
    rd(3'd4, s);  chk("R6 txvalid after flush", int'(s[3]), 0);

    // R9: SCL high time with DIV = 3
    wr(3'd5, 8'd3);
    wr(3'd2, 8'd0);
    wr(3'd0, 8'h01);
    while (scl_line) @(negedge clk);
    while (!scl_line) @(negedge clk);
    hi = 0;
    while (scl_line) begin hi++; @(negedge clk); end
    chk("R9 SCL high length", hi, 8);
    wait_idle();
    rd(3'd4, s);
    chk("R9 transfer completes at DIV 3", int'(s[0]), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule